// File: doc/BRIEF.md
# Segment-Checked Effective Address Adder

This block forms the effective address of a load or store. It adds a 16-bit signed displacement, sign-extended to 64 bits, to a 64-bit base register value. The sum and a fault flag are registered and appear one clock after the request. A request is a cycle in which `valid_i` is high.

When the tags-active mode input is high, the block checks whether the sum stays inside the aligned 16 MiB segment that the base addresses on its own. A segment here means address bits 63 down to 24, with bit 0 the least significant. If the sum leaves that segment, the block raises a segment-overflow flag. Bases whose top 16 bits are all zero are exempt from the check; these are addresses below 256 TiB. When the mode input is low, the block is a plain address adder.

The address is always delivered, including when the flag is raised. The consumer is expected to suppress the access. The segment size is fixed at 16 MiB.

Top module: `seg_ea_adder`

## Requirements
- R1: One cycle after a request, `valid_o` is high and `ea_o` equals (base + sign-extended displacement) modulo 2^64. In a cycle that follows no request, `valid_o` is low.
- R2: The displacement is two's complement. When bit 15 is set, the displacement is negative and the sum is lower than the base.
- R3: With tags-active high and base bits 63:48 not all zero, `seg_trap_o` is high exactly when `ea_o[63:24]` differs from base bits 63:24.
- R4: When base bits 63:48 are all zero, `seg_trap_o` stays low. This holds even when the sum carries into bit 48 or above.
- R5: With tags-active low, `seg_trap_o` stays low for any base and displacement.
- R6: When `seg_trap_o` is high, `ea_o` still carries the full sum.
- R7: A negative displacement that borrows below the base's segment raises `seg_trap_o` under the conditions of R3.
- R8: While `rst_ni` is low, `valid_o`, `seg_trap_o` and `ea_o` are all zero.
- R9: `seg_trap_o` is never high while `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| tags_active_i | input | 1 | Enables the segment check |
| base_i | input | 64 | Base register value |
| disp_i | input | 16 | Signed displacement |
| valid_o | output | 1 | Result valid, one cycle after the request |
| ea_o | output | 64 | Effective address |
| seg_trap_o | output | 1 | Segment-overflow flag |

## Verification
Two functions can fall in the same cycle: the exemption decided from the base, and a carry out of the sum that lands in the exempt bits. One directed case uses a base just under 256 TiB with a positive displacement. The sum's top bits then become nonzero while the base's are zero, and the bench expects the flag to stay low and the full wrapped sum to appear on `ea_o`. The reverse case also falls in one cycle: a flagged request whose address must still be exact. Trapping cases are checked on `ea_o` as well as on the flag. Random bases with low bits pushed to the segment edges produce many such coincidences, and each is judged against a bench function written from the requirements.

// File: rtl/seg_ea_pkg.sv
package seg_ea_pkg;
  localparam int unsigned SEG_LSB     = 24;  // fixed 16 MiB segment
  localparam int unsigned EXEMPT_BITS = 16;  // top bits that must be zero to bypass
endpackage

// File: rtl/seg_ea_sext.sv
module seg_ea_sext #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned OUT_W = 64
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] val_o
);
  localparam int unsigned EXT_W = OUT_W - IN_W;
  assign val_o = {{EXT_W{val_i[IN_W-1]}}, val_i};
endmodule

// File: rtl/seg_ea_chk.sv
module seg_ea_chk
  import seg_ea_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              tags_active_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] sum_i,
  output logic              trap_o
);
  localparam int unsigned SEG_W = ADDR_W - SEG_LSB;

  logic exempt;
  logic seg_diff;

  assign exempt   = ~|base_i[ADDR_W-1 -: EXEMPT_BITS];
  assign seg_diff = base_i[ADDR_W-1 -: SEG_W] != sum_i[ADDR_W-1 -: SEG_W];
  assign trap_o   = tags_active_i & ~exempt & seg_diff;
endmodule

// File: rtl/seg_ea_adder.sv
module seg_ea_adder
  import seg_ea_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DISP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              tags_active_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] ea_o,
  output logic              seg_trap_o
);
  localparam int unsigned SEG_W = ADDR_W - SEG_LSB;

  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] sum;
  logic              trap;

  seg_ea_sext #(.IN_W(DISP_W), .OUT_W(ADDR_W)) u_sext (
    .val_i (disp_i),
    .val_o (disp_ext)
  );

  assign sum = base_i + disp_ext;

  seg_ea_chk #(.ADDR_W(ADDR_W)) u_chk (
    .tags_active_i (tags_active_i),
    .base_i        (base_i),
    .sum_i         (sum),
    .trap_o        (trap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      ea_o       <= '0;
      seg_trap_o <= 1'b0;
    end else begin
      valid_o    <= valid_i;
      seg_trap_o <= valid_i & trap;
      if (valid_i) ea_o <= sum;
    end
  end

  // R1
  valid_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R5
  no_trap_inactive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !tags_active_i) |=> !seg_trap_o);

  // R4
  no_trap_exempt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && base_i[ADDR_W-1 -: EXEMPT_BITS] == '0) |=> !seg_trap_o);

  // R3
  trap_seg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && tags_active_i && base_i[ADDR_W-1 -: EXEMPT_BITS] != '0)
    |=> (seg_trap_o == (ea_o[ADDR_W-1 -: SEG_W] != $past(base_i[ADDR_W-1 -: SEG_W]))));

  // R9
  trap_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_trap_o |-> valid_o);
endmodule

// File: tb/sim_seg_ea_adder.sv
module sim_seg_ea_adder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        tags_active_i = 1'b0;
  logic [63:0] base_i = '0;
  logic [15:0] disp_i = '0;
  logic        valid_o;
  logic [63:0] ea_o;
  logic        seg_trap_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  seg_ea_adder u0 (
    .clk_i, .rst_ni, .valid_i, .tags_active_i, .base_i, .disp_i,
    .valid_o, .ea_o, .seg_trap_o
  );

  function automatic logic [63:0] exp_ea(logic [63:0] b, logic [15:0] d);
    return b + {{48{d[15]}}, d};
  endfunction

  function automatic logic exp_trap(logic ta, logic [63:0] b, logic [15:0] d);
    logic [63:0] s;
    s = exp_ea(b, d);
    return ta && (b[63:48] != 16'h0) && (s[63:24] != b[63:24]);
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic ta, logic [63:0] b, logic [15:0] d, string req);
    logic [63:0] e;
    logic        t;
    @(negedge clk_i);
    valid_i = 1'b1; tags_active_i = ta; base_i = b; disp_i = d;
    e = exp_ea(b, d);
    t = exp_trap(ta, b, d);
    @(posedge clk_i); #2;
    chk(valid_o === 1'b1, {req, " R1 valid"}, 64'(valid_o), 64'd1);
    chk(ea_o === e, {req, " R1 ea"}, ea_o, e);
    chk(seg_trap_o === t, {req, " trap"}, 64'(seg_trap_o), 64'(t));
    @(negedge clk_i);
    valid_i = 1'b0;
    base_i = ~b; tags_active_i = 1'b1;
    @(posedge clk_i); #2;
    chk(valid_o === 1'b0 && seg_trap_o === 1'b0, "R9 idle",
        {62'd0, valid_o, seg_trap_o}, 64'd0);
  endtask

  initial begin
    int unsigned seed = 32'd7;
    void'($urandom(seed));
    #20;
    chk(valid_o === 1'b0 && seg_trap_o === 1'b0 && ea_o === '0, "R8 reset",
        ea_o, 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    apply(1'b1, 64'h0001_0000_00FF_FFF0, 16'h0020, "R3 R6 cross up");
    apply(1'b0, 64'h0001_0000_00FF_FFF0, 16'h0020, "R5 inactive");
    apply(1'b1, 64'h0000_0000_00FF_FFF0, 16'h0020, "R4 exempt");
    apply(1'b1, 64'h0000_FFFF_FFFF_FFF0, 16'h0020, "R4 carry into top");
    apply(1'b1, 64'h0001_0000_0100_0004, 16'hFFF0, "R7 borrow");
    apply(1'b1, 64'h0001_0000_0100_0010, 16'hFFF0, "R2 negative stays");
    apply(1'b1, 64'h1234_5678_9A00_0000, 16'h7FFF, "R3 inside");
    apply(1'b1, 64'hFFFF_FFFF_FFFF_FFF0, 16'h0020, "R3 R6 wrap");
    apply(1'b0, 64'hFFFF_FFFF_FF00_0008, 16'h8000, "R5 R2 borrow");

    for (int i = 0; i < 1500; i++) begin
      logic [63:0] b;
      logic [15:0] d;
      logic ta;
      b  = {$urandom, $urandom};
      d  = 16'($urandom);
      ta = 1'($urandom);
      case ($urandom % 4)
        0: b[23:0] = 24'hFFFF00 | 24'($urandom % 256);
        1: b[23:0] = 24'($urandom % 256);
        2: b[63:48] = 16'h0;
        default: ;
      endcase
      apply(ta, b, d, "R3 random");
    end

    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(valid_o === 1'b0 && seg_trap_o === 1'b0 && ea_o === '0, "R8 async reset",
        ea_o, 64'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule